// File: doc/BRIEF.md
# Pin Control Unit with SPI Takeover

This block configures and drives a group of five general-purpose pins, numbered 3 to 7. Firmware uses a byte-wide register bus to program each pin. Every pin has its own configuration byte, and all five pins share one port data byte. An SPI peripheral sits beside the block. When SPI is switched on, it can take some of the pins for its own use. Each pin leaves the block as a set of pad controls: value, drive enable, open-drain, pull-up and high-sink. Each pin also gives a synchronized copy of its input level and a level-sensitive interrupt request.

Pins differ in how SPI takes them over:
- Pin 3 is taken whenever SPI is enabled.
- Pins 5 and 6 are taken only when their own select bit is also set.
- Pin 4 is taken in the same way as pins 5 and 6, but only for its output value. Its direction always stays with firmware.
- Pin 7 is never taken.

When a pin is under SPI control and the mode is master or slave, the SPI logic also sets the direction of pins 3, 5 and 6.

The register bus is a plain control path: a write takes effect on the clock edge where the strobe is high, and read data follows the address combinationally. No stream data passes through this block, so it has no valid/ready handshake and no back-pressure.

Top module: `gpio_spi_port`

## Requirements
- R1: After reset, every configuration byte and the port data byte hold 0. Every read returns 0, and every `pad_oe` bit is 0.
- R2: The configuration bytes for pins 3, 4, 5, 6 and 7 sit at addresses 0x10, 0x11, 0x12, 0x13 and 0x14. The port data byte sits at 0x01, and pin n uses bit n of it. In a configuration byte, bit 0 is drive enable, bit 1 is pull-up, bit 2 is open-drain, bit 3 is high-sink, bit 5 is interrupt active-low, bit 6 is interrupt enable, and bit 7 is SPI select (pins 4 to 6 only). Bit 4 always reads 0, and so does bit 7 on pins 3 and 7. Bits 0 to 2 of the data byte read 0. Writes to those bits, and to any other address, have no effect. Any other address reads 0.
- R3: A pin not under SPI control drives its port data bit as its value and its bit-0 enable as its direction.
- R4: Pin 3 is under SPI control whenever `spi_en` is 1. Pins 4 to 6 are under SPI control only when `spi_en` is 1 and their bit 7 is 1. A pin under SPI control takes its value from `spi_out`.
- R5: When the mode is 01 (master) or 10 (slave), pins 3, 5 and 6 under SPI control take their direction from `spi_oe`. In modes 00 and 11 they take it from bit 0. Pin 4 always takes its direction from bit 0.
- R6: Pin 7 ignores all SPI inputs and always behaves as in R3.
- R7: With open-drain set, `pad_out` is 0, and `pad_oe` is high only when the pin's direction is on and its value is 0.
- R8: `pad_od` and `pad_pu` follow bits 2 and 1 in both GPIO and SPI use. `pad_hs` follows bit 3 when the parameter `HS_EN` is 1, and is 0 when `HS_EN` is 0.
- R9: `pin_sync_o` equals `pin_in` as it was two clock edges earlier. Both synchronizer stages reset to 0.
- R10: `pin_irq` is high while bit 6 is set and the synchronized input is at the active level. The active level is low when bit 5 is 1 and high when bit 5 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| spi_en | input | 1 | SPI hardware enabled |
| spi_mode | input | 2 | 01 master, 10 slave, others neither |
| spi_out | input | 5 | SPI output value per pin (bit 0 is pin 3) |
| spi_oe | input | 5 | SPI drive enable per pin |
| pin_in | input | 5 | Raw pad input levels |
| pad_out | output | 5 | Pad output value |
| pad_oe | output | 5 | Pad drive enable |
| pad_od | output | 5 | Open-drain control |
| pad_pu | output | 5 | Pull-up control |
| pad_hs | output | 5 | High-sink control |
| pin_sync_o | output | 5 | Synchronized input levels |
| pin_irq | output | 5 | Level interrupt requests |

## Verification
A stored configuration bit that is wrong shows up on the very next read of its address. It also shows up at once on the pad controls that use it, because those controls are combinational from the registers. A pin wrongly marked as owned by SPI shows its fault as soon as `spi_out` or `spi_oe` disagrees with the firmware's values. That is why the SPI inputs are randomized every cycle. A wrong synchronizer depth or reset value shows up two edges after the input changes, on both `pin_sync_o` and `pin_irq`.

// File: rtl/gpio_spi_pkg.sv
package gpio_spi_pkg;

  typedef enum logic [1:0] {
    ROLE_SPI_ALWAYS,
    ROLE_SPI_SELECT,
    ROLE_SPI_VALUE_ONLY,
    ROLE_GPIO_ONLY
  } pin_role_e;

  // Field order matches the register bit positions, msb first.
  typedef struct packed {
    logic spi_sel;
    logic irq_en;
    logic irq_low;
    logic rsvd;
    logic hs;
    logic od;
    logic pu;
    logic oe;
  } pin_cfg_t;

  localparam logic [1:0] MODE_MASTER = 2'b01;
  localparam logic [1:0] MODE_SLAVE  = 2'b10;

  function automatic pin_role_e role_of(input int pin);
    case (pin)
      3:       return ROLE_SPI_ALWAYS;
      4:       return ROLE_SPI_VALUE_ONLY;
      5, 6:    return ROLE_SPI_SELECT;
      default: return ROLE_GPIO_ONLY;
    endcase
  endfunction

  function automatic logic [7:0] write_mask(input pin_role_e role);
    if (role == ROLE_SPI_SELECT || role == ROLE_SPI_VALUE_ONLY)
      return 8'hEF;
    return 8'h6F;
  endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_spi_pkg::*;
#(
  parameter int         NPIN      = 5,
  parameter int         PIN_BASE  = 3,
  parameter logic [7:0] CFG_BASE  = 8'h10,
  parameter logic [7:0] DATA_ADDR = 8'h01
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           addr,
  input  logic [7:0]           wdata,
  input  logic                 we,
  output logic [7:0]           rdata,
  output pin_cfg_t [NPIN-1:0]  cfg_o,
  output logic [NPIN-1:0]      data_o
);

  localparam logic [7:0] DATA_MASK = 8'(((1 << NPIN) - 1) << PIN_BASE);

  logic [7:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (we && addr == DATA_ADDR)
      data_q <= wdata & DATA_MASK;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_cfg
    localparam pin_role_e  ROLE = role_of(PIN_BASE + i);
    localparam logic [7:0] MASK = write_mask(ROLE);
    localparam logic [7:0] ADDR = CFG_BASE + 8'(i);
    logic [7:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q <= '0;
      else if (we && addr == ADDR)
        cfg_q <= wdata & MASK;
    end

    assign cfg_o[i]  = pin_cfg_t'(cfg_q);
    assign data_o[i] = data_q[PIN_BASE + i];
  end

  always_comb begin
    rdata = '0;
    if (addr == DATA_ADDR)
      rdata = data_q;
    for (int i = 0; i < NPIN; i++) begin
      if (addr == CFG_BASE + 8'(i))
        rdata = 8'(cfg_o[i]);
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPIN   = 5,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] din,
  output logic [NPIN-1:0] dout
);

  logic [STAGES-1:0][NPIN-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        chain_q[s] <= '0;
      else if (s == 0)
        chain_q[s] <= din;
      else
        chain_q[s] <= chain_q[(s == 0) ? 0 : s - 1];
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
  import gpio_spi_pkg::*;
#(
  parameter pin_role_e ROLE  = ROLE_GPIO_ONLY,
  parameter bit        HS_EN = 1'b1
) (
  input  pin_cfg_t   cfg,
  input  logic       data_bit,
  input  logic       spi_en,
  input  logic [1:0] spi_mode,
  input  logic       spi_out_bit,
  input  logic       spi_oe_bit,
  input  logic       sync_bit,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       pad_od,
  output logic       pad_pu,
  output logic       pad_hs,
  output logic       irq
);

  logic owned;
  logic auto_dir;
  logic val;
  logic dir;

  if (ROLE == ROLE_SPI_ALWAYS) begin : g_always
    assign owned    = spi_en;
    assign auto_dir = owned && (spi_mode == MODE_MASTER || spi_mode == MODE_SLAVE);
    logic unused_always;
    assign unused_always = ^{cfg.spi_sel, cfg.rsvd};
  end else if (ROLE == ROLE_SPI_SELECT) begin : g_select
    assign owned    = spi_en && cfg.spi_sel;
    assign auto_dir = owned && (spi_mode == MODE_MASTER || spi_mode == MODE_SLAVE);
    logic unused_select;
    assign unused_select = cfg.rsvd;
  end else if (ROLE == ROLE_SPI_VALUE_ONLY) begin : g_value
    assign owned    = spi_en && cfg.spi_sel;
    assign auto_dir = 1'b0;
    logic unused_value;
    assign unused_value = ^{spi_mode, spi_oe_bit, cfg.rsvd};
  end else begin : g_gpio
    assign owned    = 1'b0;
    assign auto_dir = 1'b0;
    logic unused_gpio;
    assign unused_gpio = ^{spi_en, spi_mode, spi_out_bit, spi_oe_bit, cfg.spi_sel, cfg.rsvd};
  end

  assign val = owned    ? spi_out_bit : data_bit;
  assign dir = auto_dir ? spi_oe_bit  : cfg.oe;

  always_comb begin
    if (cfg.od) begin
      pad_out = 1'b0;
      pad_oe  = dir && !val;
    end else begin
      pad_out = val;
      pad_oe  = dir;
    end
  end

  assign pad_od = cfg.od;
  assign pad_pu = cfg.pu;

  if (HS_EN) begin : g_hs_on
    assign pad_hs = cfg.hs;
  end else begin : g_hs_off
    assign pad_hs = 1'b0;
  end

  assign irq = cfg.irq_en && (sync_bit != cfg.irq_low);

endmodule

// File: rtl/gpio_spi_port.sv
module gpio_spi_port
  import gpio_spi_pkg::*;
#(
  parameter int         NPIN        = 5,
  parameter int         PIN_BASE    = 3,
  parameter logic [7:0] CFG_BASE    = 8'h10,
  parameter logic [7:0] DATA_ADDR   = 8'h01,
  parameter int         SYNC_STAGES = 2,
  parameter bit         HS_EN       = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  input  logic            bus_we,
  output logic [7:0]      bus_rdata,
  input  logic            spi_en,
  input  logic [1:0]      spi_mode,
  input  logic [NPIN-1:0] spi_out,
  input  logic [NPIN-1:0] spi_oe,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_od,
  output logic [NPIN-1:0] pad_pu,
  output logic [NPIN-1:0] pad_hs,
  output logic [NPIN-1:0] pin_sync_o,
  output logic [NPIN-1:0] pin_irq
);

  pin_cfg_t [NPIN-1:0] cfg;
  logic     [NPIN-1:0] data_bits;
  logic     [NPIN-1:0] sync_bits;

  gpio_cfg_regs #(
    .NPIN      (NPIN),
    .PIN_BASE  (PIN_BASE),
    .CFG_BASE  (CFG_BASE),
    .DATA_ADDR (DATA_ADDR)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .we     (bus_we),
    .rdata  (bus_rdata),
    .cfg_o  (cfg),
    .data_o (data_bits)
  );

  gpio_in_sync #(
    .NPIN   (NPIN),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_in),
    .dout  (sync_bits)
  );

  assign pin_sync_o = sync_bits;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    localparam pin_role_e ROLE = role_of(PIN_BASE + i);
    gpio_pin_ctl #(
      .ROLE  (ROLE),
      .HS_EN (HS_EN)
    ) u_pin (
      .cfg         (cfg[i]),
      .data_bit    (data_bits[i]),
      .spi_en      (spi_en),
      .spi_mode    (spi_mode),
      .spi_out_bit (spi_out[i]),
      .spi_oe_bit  (spi_oe[i]),
      .sync_bit    (sync_bits[i]),
      .pad_out     (pad_out[i]),
      .pad_oe      (pad_oe[i]),
      .pad_od      (pad_od[i]),
      .pad_pu      (pad_pu[i]),
      .pad_hs      (pad_hs[i]),
      .irq         (pin_irq[i])
    );
  end

endmodule

// File: rtl/gpio_spi_port_chk.sv
module gpio_spi_port_chk #(
  parameter int         NPIN      = 5,
  parameter logic [7:0] CFG_BASE  = 8'h10,
  parameter bit         HS_EN     = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      bus_addr,
  input logic            bus_we,
  input logic [7:0]      bus_rdata,
  input logic [NPIN-1:0] pin_in,
  input logic [NPIN-1:0] pin_sync_o,
  input logic [NPIN-1:0] pin_irq,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_od,
  input logic [NPIN-1:0] pad_hs
);

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      age_q <= '0;
    else if (age_q != 2'd3)
      age_q <= age_q + 2'd1;
  end

  // R1: a reset cycle leaves every pad undriven
  p_oe_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0));

  // R2: reserved bit 4 of any configuration byte reads 0
  p_rsvd_bit4_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= CFG_BASE && bus_addr < CFG_BASE + 8'(NPIN)) |-> !bus_rdata[4]);

  // R2: bit 7 of the first and last pin bytes reads 0
  p_rsvd_bit7_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CFG_BASE || bus_addr == CFG_BASE + 8'(NPIN - 1)) |-> !bus_rdata[7]);

  // R6: without a register write the last pin's pad controls stay put
  p_last_pin_no_spi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && !$past(bus_we)) |-> ($stable(pad_out[NPIN-1]) && $stable(pad_oe[NPIN-1])));

  // R9: synchronized input lags the raw input by two edges
  p_sync_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (pin_sync_o == $past(pin_in, 2)));

  // R10: irq moves only with the synchronized input or a register write
  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && !$past(bus_we) && $stable(pin_sync_o)) |-> $stable(pin_irq));

  for (genvar i = 0; i < NPIN; i++) begin : g_pin_chk
    // R7: an open-drain pad never drives a high level
    p_od_no_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pad_od[i] |-> !pad_out[i]);
  end

  if (!HS_EN) begin : g_hs_chk
    // R8: high-sink stays low when the build disables it
    p_hs_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pad_hs == '0);
  end else begin : g_hs_unused
    logic unused_hs;
    assign unused_hs = ^pad_hs;
  end

endmodule

bind gpio_spi_port gpio_spi_port_chk #(
  .NPIN     (NPIN),
  .CFG_BASE (CFG_BASE),
  .HS_EN    (HS_EN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_rdata  (bus_rdata),
  .pin_in     (pin_in),
  .pin_sync_o (pin_sync_o),
  .pin_irq    (pin_irq),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .pad_od     (pad_od),
  .pad_hs     (pad_hs)
);

// File: tb/tb_gpio_spi_port.sv
module tb_gpio_spi_port;
  localparam int N = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic [7:0]   bus_addr, bus_wdata, bus_rdata;
  logic         bus_we;
  logic         spi_en;
  logic [1:0]   spi_mode;
  logic [N-1:0] spi_out, spi_oe, pin_in;
  logic [N-1:0] pad_out, pad_oe, pad_od, pad_pu, pad_hs, pin_sync_o, pin_irq;

  gpio_spi_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .spi_en(spi_en), .spi_mode(spi_mode),
    .spi_out(spi_out), .spi_oe(spi_oe), .pin_in(pin_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu), .pad_hs(pad_hs),
    .pin_sync_o(pin_sync_o), .pin_irq(pin_irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state: configuration bytes per pin, data byte, two sync stages.
  bit [7:0]   m_cfg [N];
  bit [7:0]   m_data;
  bit [N-1:0] m_s1, m_s2;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit [7:0] ref_read(input bit [7:0] a);
    if (a == 8'h01) return m_data;
    if (a >= 8'h10 && a <= 8'h14) return m_cfg[a - 8'h10];
    return 8'h00;
  endfunction

  function automatic void ref_write(input bit [7:0] a, input bit [7:0] d);
    if (a == 8'h01) m_data = d & 8'hF8;
    else if (a == 8'h10 || a == 8'h14) m_cfg[a - 8'h10] = d & 8'h6F;
    else if (a >= 8'h11 && a <= 8'h13) m_cfg[a - 8'h10] = d & 8'hEF;
  endfunction

  // Per-pin expected pad value and enable for pin number p (3..7).
  function automatic void ref_pad(input int p, output bit o, output bit e);
    int  k = p - 3;
    bit  spi_owned, auto_dir, v, d;
    spi_owned = 0;
    if (spi_en === 1'b1) begin
      if (p == 3) spi_owned = 1;
      if (p >= 4 && p <= 6 && m_cfg[k][7]) spi_owned = 1;
    end
    auto_dir = spi_owned && p != 4 && (spi_mode == 2'b01 || spi_mode == 2'b10);
    v = spi_owned ? spi_out[k] : m_data[p];
    d = auto_dir ? spi_oe[k] : m_cfg[k][0];
    if (m_cfg[k][2]) begin
      o = 0;
      e = d && !v;
    end else begin
      o = v;
      e = d;
    end
  endfunction

  task automatic compare_all();
    bit o, e, lvl;
    chk("R2", $sformatf("rdata@%02h", bus_addr), bus_rdata, ref_read(bus_addr));
    for (int k = 0; k < N; k++) begin
      ref_pad(k + 3, o, e);
      chk("R3 R4", $sformatf("pad_out[%0d]", k), pad_out[k], o);
      chk("R5 R7", $sformatf("pad_oe[%0d]", k), pad_oe[k], e);
      chk("R8", $sformatf("pad_od[%0d]", k), pad_od[k], m_cfg[k][2]);
      chk("R8", $sformatf("pad_pu[%0d]", k), pad_pu[k], m_cfg[k][1]);
      chk("R8", $sformatf("pad_hs[%0d]", k), pad_hs[k], m_cfg[k][3]);
      chk("R9", $sformatf("pin_sync_o[%0d]", k), pin_sync_o[k], m_s2[k]);
      lvl = m_cfg[k][5] ? 1'b0 : 1'b1;
      chk("R10", $sformatf("pin_irq[%0d]", k), pin_irq[k], m_cfg[k][6] && (m_s2[k] == lvl));
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (bus_we) ref_write(bus_addr, bus_wdata);
    m_s2 = m_s1;
    m_s1 = pin_in;
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input bit [7:0] a, input bit [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_addr = 0; bus_wdata = 0; bus_we = 0;
    spi_en = 0; spi_mode = 0; spi_out = 0; spi_oe = 0; pin_in = 0;
    for (int k = 0; k < N; k++) m_cfg[k] = 0;
    m_data = 0; m_s1 = 0; m_s2 = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1: reset state visible at every mapped address and on the pads
    for (int a = 0; a < 32; a++) begin
      bus_addr = 8'(a);
      #1;
      chk("R1", $sformatf("reset read @%02h", a), bus_rdata, 0);
    end
    chk("R1", "reset pad_oe", pad_oe, 0);
    @(negedge clk);

    // R3: pin 5 as plain GPIO
    wr(8'h12, 8'h01);
    wr(8'h01, 8'h20);
    chk("R3", "pin5 gpio out", pad_out[2], 1);
    chk("R3", "pin5 gpio oe", pad_oe[2], 1);

    // R6: pin 7 ignores bit 7 and SPI
    wr(8'h14, 8'h81);
    bus_addr = 8'h14; #1;
    chk("R6", "pin7 bit7 dropped", bus_rdata, 8'h01);
    spi_en = 1; spi_mode = 2'b01; spi_out = '0; spi_oe = '0;
    wr(8'h01, 8'h80);
    chk("R6", "pin7 stays gpio out", pad_out[4], 1);
    chk("R6", "pin7 stays gpio oe", pad_oe[4], 1);

    // R5: pin 4 direction stays with firmware even in master mode
    spi_oe = '1; spi_out = 5'b00010;
    wr(8'h11, 8'h80);
    chk("R5", "pin4 oe from cfg", pad_oe[1], 0);
    chk("R4", "pin4 value from spi", pad_out[1], 1);
    // R5: pin 3 direction from SPI in master mode, from cfg in mode 11
    chk("R5", "pin3 oe from spi", pad_oe[0], 1);
    spi_mode = 2'b11;
    step();
    chk("R5", "pin3 oe from cfg in mode 11", pad_oe[0], 0);

    // R7: open drain on pin 6 driving high releases the pad
    spi_en = 0;
    wr(8'h13, 8'h05);
    wr(8'h01, 8'h40);
    chk("R7", "pin6 od high released", pad_oe[3], 0);
    wr(8'h01, 8'h00);
    chk("R7", "pin6 od low driven", pad_oe[3], 1);

    // R10: active-low interrupt on pin 3
    wr(8'h10, 8'h60);
    pin_in = 5'b00001;
    step(); step();
    chk("R10", "pin3 irq idle high input", pin_irq[0], 0);
    pin_in = 5'b00000;
    step();
    chk("R9", "sync one edge late", pin_sync_o[0], 1);
    step();
    chk("R10", "pin3 irq on low", pin_irq[0], 1);

    // Randomized traffic compared every cycle (R2 to R10)
    for (int c = 0; c < 4000; c++) begin
      int pick = $urandom % 8;
      bus_we    = ($urandom % 3) == 0;
      bus_addr  = (pick == 0) ? 8'h01 : (pick < 6) ? 8'h10 + 8'(pick - 1) : 8'($urandom);
      bus_wdata = 8'($urandom);
      if (($urandom % 16) == 0) spi_en = ~spi_en;
      spi_mode = 2'($urandom);
      spi_out  = N'($urandom);
      spi_oe   = N'($urandom);
      pin_in   = N'($urandom);
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule